// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block tracks the fetch state of every hardware thread in a multithreaded instruction-fetch stage and advances each state once per clock. Later pipeline stages tell it when a thread must pause, through sticky block and unblock pulses, and when it must redirect, through squash requests with a target PC. The instruction cache reports whether a request was accepted or refused, when a refused request may be resent, and when a response comes back. From all of this the block produces each thread's status, its redirect PC and the PC that follows it, a small tag for the thread's outstanding request, a cache-blocked flag and a stage-active flag.

Only one refused request can be parked at a time, in a single retry slot shared by all threads. While that slot is in use, the cache-blocked flag is high and new requests are ignored. A squash advances the thread's request tag. A response that arrives late for a squashed request then carries a stale tag, and the block drops it.

Top module: `fetch_status_ctrl`

## Requirements
- R1: Each thread has one sticky stall bit per downstream stage, at index thread*4+stage, with stage 0 = decode, 1 = rename, 2 = execute and 3 = commit. A block pulse sets the bit and an unblock pulse clears it. A thread counts as stalled in a cycle if any of its bits, including this cycle's updates, is set, or if `ctx_stall_i` is high.
- R2: Each cycle, a thread takes the first of these that applies: commit squash, commit still-squashing, decode squash, stall (the thread goes to Blocked), then a return to Running from Blocked or Squashing. Cache events are handled only when none of these applies.
- R3: A decode squash has no effect on a thread that is already in Squashing. Its status, PC and tag stay as they were.
- R4: A stall does not move a thread out of WaitResp.
- R5: A squash that takes effect moves the thread to Squashing, sets the PC to the target and the next PC to the target plus 4, and adds 1 to the thread's request tag (modulo 2^TAG_W).
- R6: An issue for a thread in Running, made while the cache is not blocked, moves the thread to WaitResp if it is accepted. If it is refused, the thread goes to WaitRetry and `cache_blocked_o` rises. An issue made in any other situation is ignored.
- R7: A retry grant with an accepted resend moves the thread waiting in the retry slot to WaitResp and clears `cache_blocked_o`. A retry grant whose resend is refused changes nothing.
- R8: When the owner of the retry slot leaves WaitRetry by any route (a squash, a still-squashing flag or a stall), the slot is freed and `cache_blocked_o` falls.
- R9: A response changes a thread's status only if the thread is in WaitResp and the response tag equals its request tag. The thread then goes to Blocked if it is stalled and to AccessDone if not. Any other response raises `resp_drop_o` in the same cycle and is discarded.
- R10: A thread in AccessDone with no other event returns to Running one cycle later.
- R11: `active_o` is high exactly when at least one thread is in Running, Squashing or AccessDone.
- R12: After reset every thread is in Running with its stall bits clear, its PC at RESET_PC, its next PC at RESET_PC+4 and its tag at 0, and the retry slot is empty. Status codes are Running=0, Blocked=1, Squashing=2, WaitRetry=3, WaitResp=4, AccessDone=5, three bits per thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_block_i | input | NUM_THREADS*4 | Block pulses, per thread and stage |
| stage_unblock_i | input | NUM_THREADS*4 | Unblock pulses, per thread and stage |
| ctx_stall_i | input | 1 | Global context-switch stall |
| cmt_squash_i | input | NUM_THREADS | Squash request from commit |
| cmt_target_i | input | NUM_THREADS*PC_W | Redirect PCs for commit squashes |
| cmt_busy_i | input | NUM_THREADS | Commit is still squashing |
| dec_squash_i | input | NUM_THREADS | Squash request from decode |
| dec_target_i | input | NUM_THREADS*PC_W | Redirect PCs for decode squashes |
| ic_issue_i | input | 1 | A cache request is sent this cycle |
| ic_issue_tid_i | input | TID_W | Thread that sent the request |
| ic_issue_ok_i | input | 1 | The cache accepted the request |
| ic_retry_i | input | 1 | The cache grants a resend |
| ic_retry_ok_i | input | 1 | The resend was accepted |
| ic_resp_i | input | 1 | A cache response arrives |
| ic_resp_tid_i | input | TID_W | Thread the response belongs to |
| ic_resp_tag_i | input | TAG_W | Tag carried by the response |
| status_o | output | NUM_THREADS*3 | Status of each thread |
| pc_o | output | NUM_THREADS*PC_W | PC of each thread |
| npc_o | output | NUM_THREADS*PC_W | Next PC of each thread |
| req_tag_o | output | NUM_THREADS*TAG_W | Request tag of each thread |
| cache_blocked_o | output | 1 | The retry slot is occupied |
| resp_drop_o | output | 1 | This cycle's response is discarded |
| active_o | output | 1 | The stage has work this cycle |

## Verification
The bench targets the collisions between events. A squash can land while a thread waits for a response; a design that did not advance the tag would then accept the late response and let a redirected thread consume stale data. A stall can arrive during WaitResp; a design that ignored R4 would move the thread to Blocked and then lose the response. A thread can leave WaitRetry through a squash or a stall; a design that did not free the slot would keep `cache_blocked_o` high for good and block fetch for every thread. Cycles that stack commit squash, still-squashing, decode squash and stall show any mistake in the priority order as a wrong PC or a wrong status.

// File: rtl/fsc_pkg.sv
// Shared types for the per-thread fetch status controller.
package fsc_pkg;
    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_BLOCKED = 3'd1,
        ST_SQUASH  = 3'd2,
        ST_WRETRY  = 3'd3,
        ST_WRESP   = 3'd4,
        ST_DONE    = 3'd5
    } fstat_e;
endpackage

// File: rtl/fsc_stall_latch.sv
// Sticky per-stage stall bits for one thread.
// Assumes an unblock pulse never coincides with a block pulse on the same
// bit and only arrives while that bit is set.
module fsc_stall_latch #(
    parameter int NUM_STAGES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STAGES-1:0] block_i,
    input  logic [NUM_STAGES-1:0] unblock_i,
    input  logic                  ctx_stall_i,
    output logic                  stalled_o
);
    logic [NUM_STAGES-1:0] bits_q;
    logic [NUM_STAGES-1:0] bits_n;

    // Apply this cycle's set and clear pulses.
    always_comb bits_n = (bits_q | block_i) & ~unblock_i;

    // Hold the sticky bits.
    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_n;
    end

    // The thread is stalled by any stage or by a context switch.
    always_comb stalled_o = (|bits_n) | ctx_stall_i;

    // R1: an unblock only arrives for a bit that is set and not being set again.
    p_unblock_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((unblock_i & ~bits_q) == '0) && ((unblock_i & block_i) == '0));
endmodule

// File: rtl/fsc_thread_fsm.sv
// Status, PC and request tag of one thread.
// Applies squash, stall and resume in fixed priority, then cache events.
module fsc_thread_fsm
    import fsc_pkg::*;
#(
    parameter int          PC_W     = 32,
    parameter int          TAG_W    = 2,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stalled_i,
    input  logic             cmt_squash_i,
    input  logic [PC_W-1:0]  cmt_target_i,
    input  logic             cmt_busy_i,
    input  logic             dec_squash_i,
    input  logic [PC_W-1:0]  dec_target_i,
    input  logic             issue_go_i,
    input  logic             issue_ok_i,
    input  logic             retry_go_i,
    input  logic             resp_sel_i,
    input  logic [TAG_W-1:0] resp_tag_i,
    output fstat_e           status_o,
    output fstat_e           status_next_o,
    output logic [PC_W-1:0]  pc_o,
    output logic [PC_W-1:0]  npc_o,
    output logic [TAG_W-1:0] tag_o,
    output logic             resp_hit_o
);
    localparam logic [PC_W-1:0] PC_INIT = PC_W'(RESET_PC);
    localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

    fstat_e            st_q, st_n;
    logic [PC_W-1:0]   pc_q, pc_n, npc_q;
    logic [TAG_W-1:0]  tag_q, tag_n;

    // A response counts only in WaitResp with the current tag.
    always_comb resp_hit_o = resp_sel_i && (st_q == ST_WRESP) && (resp_tag_i == tag_q);

    // Next-state selection in priority order.
    always_comb begin
        st_n  = st_q;
        pc_n  = pc_q;
        tag_n = tag_q;
        if (cmt_squash_i) begin
            st_n  = ST_SQUASH;
            pc_n  = cmt_target_i;
            tag_n = tag_q + TAG_W'(1);
        end else if (cmt_busy_i) begin
            st_n = ST_SQUASH;
        end else if (dec_squash_i && st_q != ST_SQUASH) begin
            st_n  = ST_SQUASH;
            pc_n  = dec_target_i;
            tag_n = tag_q + TAG_W'(1);
        end else if (stalled_i && st_q != ST_WRESP) begin
            st_n = ST_BLOCKED;
        end else if (st_q == ST_BLOCKED || st_q == ST_SQUASH) begin
            st_n = ST_RUN;
        end else if (resp_hit_o) begin
            st_n = stalled_i ? ST_BLOCKED : ST_DONE;
        end else if (retry_go_i && st_q == ST_WRETRY) begin
            st_n = ST_WRESP;
        end else if (issue_go_i && st_q == ST_RUN) begin
            st_n = issue_ok_i ? ST_WRESP : ST_WRETRY;
        end else if (st_q == ST_DONE) begin
            st_n = ST_RUN;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            pc_q  <= PC_INIT;
            npc_q <= PC_INIT + PC_STEP;
            tag_q <= '0;
        end else begin
            st_q  <= st_n;
            pc_q  <= pc_n;
            npc_q <= pc_n + PC_STEP;
            tag_q <= tag_n;
        end
    end

    assign status_o      = st_q;
    assign status_next_o = st_n;
    assign pc_o          = pc_q;
    assign npc_o         = npc_q;
    assign tag_o         = tag_q;

    // R5: a commit squash redirects both PCs one cycle later.
    p_redirect_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_squash_i |=> (pc_o == $past(cmt_target_i)) && (npc_o == $past(cmt_target_i) + PC_STEP));

    // R3: a decode squash in Squashing leaves the PC alone.
    p_dec_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_squash_i && !cmt_squash_i && st_q == ST_SQUASH) |=> $stable(pc_q) && $stable(tag_q));

    // R4: WaitResp survives a stall until a response or squash.
    p_wresp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WRESP && !cmt_squash_i && !cmt_busy_i && !dec_squash_i && !resp_hit_o)
        |=> (st_q == ST_WRESP));

    // R9: a matching response always leaves WaitResp for Blocked or AccessDone.
    p_resp_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_hit_o && !cmt_squash_i && !cmt_busy_i && !dec_squash_i)
        |=> (st_q == ST_BLOCKED || st_q == ST_DONE));
endmodule

// File: rtl/fsc_retry_slot.sv
// Single shared slot for a refused cache request.
// Assumes at most one thread is headed for WaitRetry in any cycle.
module fsc_retry_slot #(
    parameter int NUM_THREADS = 2,
    parameter int TID_W       = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] wait_next_i,
    output logic                   busy_o,
    output logic [TID_W-1:0]       owner_o
);
    logic             busy_q;
    logic [TID_W-1:0] owner_q, owner_n;

    // Encode the thread that will hold the slot.
    always_comb begin
        owner_n = owner_q;
        for (int t = 0; t < NUM_THREADS; t++)
            if (wait_next_i[t]) owner_n = TID_W'(t);
    end

    // Slot register: occupied while its owner sits in WaitRetry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            owner_q <= '0;
        end else begin
            busy_q  <= |wait_next_i;
            owner_q <= owner_n;
        end
    end

    assign busy_o  = busy_q;
    assign owner_o = owner_q;

    // R8: at most one thread ever holds the retry slot.
    p_single_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wait_next_i));

    // R7: a freed slot reads as not blocked on the following cycle.
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && wait_next_i == '0) |=> !busy_o);
endmodule

// File: rtl/fetch_status_ctrl.sv
// Per-thread fetch status controller: stall latches, per-thread state
// machines and a shared retry slot, plus the stage-active summary.
// Assumes stage pulses follow the block/unblock protocol.
module fetch_status_ctrl
    import fsc_pkg::*;
#(
    parameter int          NUM_THREADS = 2,
    parameter int          PC_W        = 32,
    parameter int          TAG_W       = 2,
    parameter logic [31:0] RESET_PC    = 32'h0,
    parameter int          TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_THREADS*4-1:0]     stage_block_i,
    input  logic [NUM_THREADS*4-1:0]     stage_unblock_i,
    input  logic                         ctx_stall_i,
    input  logic [NUM_THREADS-1:0]       cmt_squash_i,
    input  logic [NUM_THREADS*PC_W-1:0]  cmt_target_i,
    input  logic [NUM_THREADS-1:0]       cmt_busy_i,
    input  logic [NUM_THREADS-1:0]       dec_squash_i,
    input  logic [NUM_THREADS*PC_W-1:0]  dec_target_i,
    input  logic                         ic_issue_i,
    input  logic [TID_W-1:0]             ic_issue_tid_i,
    input  logic                         ic_issue_ok_i,
    input  logic                         ic_retry_i,
    input  logic                         ic_retry_ok_i,
    input  logic                         ic_resp_i,
    input  logic [TID_W-1:0]             ic_resp_tid_i,
    input  logic [TAG_W-1:0]             ic_resp_tag_i,
    output logic [NUM_THREADS*3-1:0]     status_o,
    output logic [NUM_THREADS*PC_W-1:0]  pc_o,
    output logic [NUM_THREADS*PC_W-1:0]  npc_o,
    output logic [NUM_THREADS*TAG_W-1:0] req_tag_o,
    output logic                         cache_blocked_o,
    output logic                         resp_drop_o,
    output logic                         active_o
);
    localparam int NUM_STAGES = 4;

    logic [NUM_THREADS-1:0] stalled, wait_next, resp_hit, works;
    logic [TID_W-1:0]       slot_owner;
    logic                   slot_busy;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        fstat_e st, st_next;

        fsc_stall_latch #(.NUM_STAGES(NUM_STAGES)) u_stall (
            .clk        (clk),
            .rst_n      (rst_n),
            .block_i    (stage_block_i[t*NUM_STAGES +: NUM_STAGES]),
            .unblock_i  (stage_unblock_i[t*NUM_STAGES +: NUM_STAGES]),
            .ctx_stall_i(ctx_stall_i),
            .stalled_o  (stalled[t])
        );

        fsc_thread_fsm #(.PC_W(PC_W), .TAG_W(TAG_W), .RESET_PC(RESET_PC)) u_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .stalled_i    (stalled[t]),
            .cmt_squash_i (cmt_squash_i[t]),
            .cmt_target_i (cmt_target_i[t*PC_W +: PC_W]),
            .cmt_busy_i   (cmt_busy_i[t]),
            .dec_squash_i (dec_squash_i[t]),
            .dec_target_i (dec_target_i[t*PC_W +: PC_W]),
            .issue_go_i   (ic_issue_i && !slot_busy && ic_issue_tid_i == TID_W'(t)),
            .issue_ok_i   (ic_issue_ok_i),
            .retry_go_i   (ic_retry_i && ic_retry_ok_i && slot_busy && slot_owner == TID_W'(t)),
            .resp_sel_i   (ic_resp_i && ic_resp_tid_i == TID_W'(t)),
            .resp_tag_i   (ic_resp_tag_i),
            .status_o     (st),
            .status_next_o(st_next),
            .pc_o         (pc_o[t*PC_W +: PC_W]),
            .npc_o        (npc_o[t*PC_W +: PC_W]),
            .tag_o        (req_tag_o[t*TAG_W +: TAG_W]),
            .resp_hit_o   (resp_hit[t])
        );

        // Per-thread summaries for the slot and the active flag.
        always_comb begin
            wait_next[t] = (st_next == ST_WRETRY);
            works[t]     = (st == ST_RUN) || (st == ST_SQUASH) || (st == ST_DONE);
        end
        assign status_o[t*3 +: 3] = st;
    end

    fsc_retry_slot #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .wait_next_i(wait_next),
        .busy_o     (slot_busy),
        .owner_o    (slot_owner)
    );

    // Top-level flags.
    always_comb begin
        cache_blocked_o = slot_busy;
        resp_drop_o     = ic_resp_i && (resp_hit == '0);
        active_o        = |works;
    end

    // R6: a refused issue on a free cache raises the blocked flag.
    p_refuse_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_issue_i && !ic_issue_ok_i && !cache_blocked_o && wait_next != '0) |=> cache_blocked_o);
endmodule

// File: tb/sim_fetch_status_ctrl.sv
// Bench: behavioural reference model compared with the design every cycle.
module sim_fetch_status_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 2;
    localparam int PW = 32;
    localparam int TW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT*4-1:0]  blk, unb;
    logic             ctx;
    logic [NT-1:0]    csq, cbusy, dsq;
    logic [NT*PW-1:0] ctgt, dtgt;
    logic iss, iss_ok, rty, rty_ok, rsp;
    logic [0:0] iss_tid, rsp_tid;
    logic [TW-1:0] rsp_tag;
    logic [NT*3-1:0]  status;
    logic [NT*PW-1:0] pc, npc;
    logic [NT*TW-1:0] rtag;
    logic cblk, drop, act;

    int checks = 0;
    int errors = 0;

    // Reference state
    int         mst[NT];
    logic [31:0] mpc[NT];
    logic [1:0]  mtag[NT];
    logic [3:0]  msb[NT];
    bit          mslot;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_status_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .stage_block_i(blk), .stage_unblock_i(unb),
        .ctx_stall_i(ctx), .cmt_squash_i(csq), .cmt_target_i(ctgt), .cmt_busy_i(cbusy),
        .dec_squash_i(dsq), .dec_target_i(dtgt), .ic_issue_i(iss), .ic_issue_tid_i(iss_tid),
        .ic_issue_ok_i(iss_ok), .ic_retry_i(rty), .ic_retry_ok_i(rty_ok), .ic_resp_i(rsp),
        .ic_resp_tid_i(rsp_tid), .ic_resp_tag_i(rsp_tag), .status_o(status), .pc_o(pc),
        .npc_o(npc), .req_tag_o(rtag), .cache_blocked_o(cblk), .resp_drop_o(drop), .active_o(act)
    );

    task automatic chk(input bit ok, input string lbl, input string what,
                       input longint act_v, input longint exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", lbl, what, act_v, exp_v);
        end
    endtask

    task automatic idle();
        blk = '0; unb = '0; ctx = 0; csq = '0; cbusy = '0; dsq = '0;
        ctgt = '0; dtgt = '0; iss = 0; iss_tid = '0; iss_ok = 0;
        rty = 0; rty_ok = 0; rsp = 0; rsp_tid = '0; rsp_tag = '0;
    endtask

    task automatic model_reset();
        for (int t = 0; t < NT; t++) begin
            mst[t] = 0; mpc[t] = 32'h0; mtag[t] = 2'd0; msb[t] = 4'h0;
        end
        mslot = 0;
    endtask

    function automatic bit m_drop();
        int t;
        t = int'(rsp_tid);
        return rsp && !(mst[t] == 4 && mtag[t] == rsp_tag);
    endfunction

    function automatic bit m_active();
        bit a = 0;
        for (int t = 0; t < NT; t++) if (mst[t] == 0 || mst[t] == 2 || mst[t] == 5) a = 1;
        return a;
    endfunction

    // Advance the reference by one clock using the current inputs.
    task automatic model_step();
        int ns[NT];
        bit st_l;
        bit any_wr = 0;
        for (int t = 0; t < NT; t++) begin
            msb[t] = (msb[t] | blk[t*4 +: 4]) & ~unb[t*4 +: 4];
            st_l = (msb[t] != 0) || ctx;
            ns[t] = mst[t];
            if (csq[t]) begin
                ns[t] = 2; mpc[t] = ctgt[t*PW +: PW]; mtag[t] = mtag[t] + 2'd1;
            end else if (cbusy[t]) ns[t] = 2;
            else if (dsq[t] && mst[t] != 2) begin
                ns[t] = 2; mpc[t] = dtgt[t*PW +: PW]; mtag[t] = mtag[t] + 2'd1;
            end else if (st_l && mst[t] != 4) ns[t] = 1;
            else if (mst[t] == 1 || mst[t] == 2) ns[t] = 0;
            else if (mst[t] == 4 && rsp && int'(rsp_tid) == t && rsp_tag == mtag[t])
                ns[t] = st_l ? 1 : 5;
            else if (mst[t] == 3 && rty && rty_ok) ns[t] = 4;
            else if (mst[t] == 0 && iss && int'(iss_tid) == t && !mslot)
                ns[t] = iss_ok ? 4 : 3;
            else if (mst[t] == 5) ns[t] = 0;
        end
        for (int t = 0; t < NT; t++) begin
            mst[t] = ns[t];
            if (ns[t] == 3) any_wr = 1;
        end
        mslot = any_wr;
    endtask

    task automatic compare_regs(input string lbl);
        for (int t = 0; t < NT; t++) begin
            chk(int'(status[t*3 +: 3]) == mst[t], lbl, $sformatf("status[%0d]", t),
                longint'(status[t*3 +: 3]), longint'(mst[t]));
            chk(pc[t*PW +: PW] == mpc[t], lbl, $sformatf("pc[%0d]", t),
                longint'(pc[t*PW +: PW]), longint'(mpc[t]));
            chk(npc[t*PW +: PW] == mpc[t] + 32'd4, lbl, $sformatf("npc[%0d]", t),
                longint'(npc[t*PW +: PW]), longint'(mpc[t] + 32'd4));
            chk(rtag[t*TW +: TW] == mtag[t], lbl, $sformatf("tag[%0d]", t),
                longint'(rtag[t*TW +: TW]), longint'(mtag[t]));
        end
        chk(cblk == mslot, lbl, "cache_blocked", longint'(cblk), longint'(mslot));
    endtask

    // One cycle: inputs already driven at the falling edge.
    task automatic cyc(input string lbl);
        #1;
        chk(act == m_active(), lbl, "active", longint'(act), longint'(m_active()));
        chk(drop == m_drop(), lbl, "resp_drop", longint'(drop), longint'(m_drop()));
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_regs(lbl);
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_regs("R12 reset");
        cyc("R12 idle");

        // R1: stall bit, then release returns to Running
        blk[0*4 + 0] = 1; cyc("R1 decode block");
        cyc("R1 hold");
        unb[0*4 + 0] = 1; cyc("R1 unblock");
        cyc("R2 resume");
        ctx = 1; cyc("R1 ctx stall");
        ctx = 1; cyc("R11 all blocked inactive");
        cyc("R2 resume after ctx");

        // R6/R9/R4: request, stale response, stall in WaitResp, response
        iss = 1; iss_tid = 0; iss_ok = 1; cyc("R6 issue accepted");
        rsp = 1; rsp_tid = 0; rsp_tag = 2'd3; cyc("R9 wrong tag dropped");
        blk[0*4 + 1] = 1; cyc("R4 stall in WaitResp");
        rsp = 1; rsp_tid = 0; rsp_tag = 2'd0; cyc("R9 match while stalled");
        unb[0*4 + 1] = 1; cyc("R2 unblock");
        iss = 1; iss_tid = 0; iss_ok = 1; cyc("R6 issue again");
        rsp = 1; rsp_tid = 0; rsp_tag = 2'd0; cyc("R9 match to AccessDone");
        cyc("R10 AccessDone to Running");

        // R6/R7: refused issue, blocked cache, retry
        iss = 1; iss_tid = 0; iss_ok = 0; cyc("R6 issue refused");
        iss = 1; iss_tid = 1; iss_ok = 1; cyc("R6 issue ignored while blocked");
        rty = 1; rty_ok = 0; cyc("R7 resend refused");
        rty = 1; rty_ok = 1; cyc("R7 resend accepted");

        // R5: commit squash during WaitResp, then the late response
        csq[0] = 1; ctgt[0*PW +: PW] = 32'h100; cyc("R5 commit squash");
        rsp = 1; rsp_tid = 0; rsp_tag = 2'd0; cyc("R9 late response dropped");

        // R8: owner of the slot squashed by decode
        iss = 1; iss_tid = 1; iss_ok = 0; cyc("R6 t1 refused");
        dsq[1] = 1; dtgt[1*PW +: PW] = 32'h240; cyc("R8 squash frees slot");
        cyc("R2 back to running");
        iss = 1; iss_tid = 1; iss_ok = 0; cyc("R6 t1 refused again");
        blk[1*4 + 3] = 1; cyc("R8 stall frees slot");
        unb[1*4 + 3] = 1; cyc("R1 commit unblock");

        // R2/R3: stacked priorities
        csq[0] = 1; ctgt[0*PW +: PW] = 32'h300; cbusy[0] = 1; dsq[0] = 1;
        dtgt[0*PW +: PW] = 32'h400; blk[0*4 + 2] = 1; cyc("R2 commit squash wins");
        cbusy[0] = 1; dsq[0] = 1; dtgt[0*PW +: PW] = 32'h500; cyc("R2 busy beats decode");
        dsq[0] = 1; dtgt[0*PW +: PW] = 32'h600; cyc("R3 decode ignored in Squashing");
        unb[0*4 + 2] = 1; cyc("R2 stall after squash");
        cyc("R2 resume");

        // Mixed random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            for (int t = 0; t < NT; t++) begin
                for (int s = 0; s < 4; s++) begin
                    int r;
                    r = int'($urandom % 12);
                    if (r == 0 && !msb[t][s]) blk[t*4 + s] = 1;
                    else if (r == 1 && msb[t][s]) unb[t*4 + s] = 1;
                end
                csq[t]   = ($urandom % 25) == 0;
                cbusy[t] = ($urandom % 30) == 0;
                dsq[t]   = ($urandom % 20) == 0;
                ctgt[t*PW +: PW] = {$urandom} & 32'hFFFF_FFFC;
                dtgt[t*PW +: PW] = {$urandom} & 32'hFFFF_FFFC;
            end
            ctx     = ($urandom % 40) == 0;
            iss     = ($urandom % 3) == 0;
            iss_tid = 1'($urandom);
            iss_ok  = ($urandom % 3) != 0;
            rty     = ($urandom % 3) == 0;
            rty_ok  = ($urandom % 2) == 0;
            rsp     = ($urandom % 3) == 0;
            rsp_tid = 1'($urandom);
            rsp_tag = (($urandom % 4) == 0) ? 2'($urandom) : mtag[int'(rsp_tid)];
            cyc("R2 random mix");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule